// File: doc/BRIEF.md
# Converter Sample Sequencer

This block sets the pace for a sampled signal path that sits between a serial analog-to-digital converter and a serial digital-to-analog converter. It divides the system clock down to the sample rate, which is rounded to the nearest whole number of clocks. On each sample tick it opens an acquisition window on the input converter, and it flags the clock in which the word is captured. Right after that it opens an output frame on the output converter, which carries the most recent filtered result. The bit-level serial shifting to both converters is modelled only as a fixed number of system clocks per frame.

Each captured input word also goes into a single-in parallel-out delay line. The delay line gives the downstream filter arithmetic the newest sample and a set of older ones. A tick can arrive while a frame is still running. The current frame always finishes first, and at most one tick is held to be served after it.

Top module: `cvt_sample_sequencer`

## Requirements
- R1: `sample_tick_o` is a one-cycle pulse that repeats every P = round(CLK_HZ/FS_HZ) clocks, with halves rounded up. The internal divider restarts at 0 on reset, so the first pulse comes in cycle P-1, counting the first cycle after reset release as cycle 0.
- R2: During reset and in the cycle reset is released, both enables and `sample_done_o` are low, both active-low selects are high, and every delay-line tap and `dac_word_o` read zero.
- R3: A tick that finds the block idle starts acquisition on the next clock. `adc_rd_en_o` is then high and `adc_cs_n_o` low for exactly F = FRAME_BITS*SCLK_DIV cycles.
- R4: `sample_done_o` is high for one cycle only, the last cycle of each acquisition window.
- R5: The output frame starts in the cycle after `sample_done_o`. For F cycles `dac_wr_en_o` is high and `dac_sync_n_o` low, and then both return to idle (low and high).
- R6: A tick that arrives during acquisition or during an output frame is held pending. The next acquisition starts in the cycle right after that output frame's last cycle. Only one tick can be pending, and further ticks that arrive before it is served are dropped.
- R7: On the clock edge that ends a `sample_done_o` cycle, tap 0 (bits W-1:0 of `taps_o`) loads `adc_word_i` and tap k (bits k*W+W-1:k*W) loads the old tap k-1. The taps do not change on any other edge.
- R8: `dac_word_o` loads `dac_word_i` on the edge that ends a `sample_done_o` cycle and holds that value until the next one.
- R9: `adc_rd_en_o` and `dac_wr_en_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_word_i | input | SAMPLE_W | Word delivered by the input converter's serial shifter |
| dac_word_i | input | SAMPLE_W | Latest filtered result to be sent out |
| sample_tick_o | output | 1 | One-cycle sample-rate pulse |
| adc_rd_en_o | output | 1 | Acquisition window active |
| adc_cs_n_o | output | 1 | Input converter select, active low |
| sample_done_o | output | 1 | Last cycle of acquisition; word captured at its end |
| dac_wr_en_o | output | 1 | Output frame active |
| dac_sync_n_o | output | 1 | Output converter frame sync, active low |
| dac_word_o | output | SAMPLE_W | Word held for the current output frame |
| taps_o | output | TAPS*SAMPLE_W | Delay-line taps, tap 0 (newest) in the low bits |

## Verification
The properties assume that `adc_word_i` is valid in the clock of `sample_done_o`, and that `dac_word_i` already holds the next filtered result at that point. The bench changes both inputs on every clock, so each captured value identifies the exact cycle in which it was sampled. The properties make no assumption about the ratio of sample period to frame length. The stimulus therefore uses two instances. The first has a 20-clock period, which leaves idle gaps. The second has a 12-clock period, shorter than the 16 clocks of one acquisition plus one output frame, so ticks land inside frames and the pending and dropping rules are exercised.

// File: rtl/smp_pkg.sv
package smp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_DAC  = 2'd2
    } phase_e;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
        logic done;
    } seq_ctl_t;

    // Nearest whole number of clocks per sample, halves rounded up.
    function automatic int unsigned ticks_per_sample(int unsigned clk_hz, int unsigned fs_hz);
        return (clk_hz + fs_hz / 2) / fs_hz;
    endfunction

    // Bits needed to count 0 .. n-1, never less than one.
    function automatic int unsigned cnt_width(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/smp_rate_div.sv
module smp_rate_div #(
    parameter int unsigned PERIOD = 1134
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CW = smp_pkg::cnt_width(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/smp_frame_fsm.sv
module smp_frame_fsm #(
    parameter int unsigned FRAME_CLKS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    output smp_pkg::seq_ctl_t ctl_o
);
    import smp_pkg::*;

    localparam int unsigned CW = cnt_width(FRAME_CLKS);
    localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

    phase_e        phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pend_q, pend_d;
    logic          last, req, accept;

    assign last = (cnt_q == LAST);
    assign req  = tick_i | pend_q;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (req) begin
                    phase_d = PH_ACQ;
                    accept  = 1'b1;
                end
            end
            PH_ACQ: begin
                if (last) begin
                    phase_d = PH_DAC;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_DAC: begin
                if (last) begin
                    cnt_d = '0;
                    if (req) begin
                        phase_d = PH_ACQ;
                        accept  = 1'b1;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
        // A served request clears the pending slot; a surplus tick is lost.
        pend_d = accept ? 1'b0 : (pend_q | tick_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        ctl_o.rd_en = (phase_q == PH_ACQ);
        ctl_o.wr_en = (phase_q == PH_DAC);
        ctl_o.done  = (phase_q == PH_ACQ) && last;
    end
endmodule

// File: rtl/smp_delay_line.sv
module smp_delay_line #(
    parameter int unsigned W    = 12,
    parameter int unsigned TAPS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_i,
    input  logic [W-1:0]      din_i,
    output logic [TAPS*W-1:0] taps_o
);
    logic [W-1:0] stage_q [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_stage
        logic [W-1:0] src;
        if (g == 0) begin : g_head
            assign src = din_i;
        end else begin : g_body
            assign src = stage_q[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= '0;
            end else if (shift_i) begin
                stage_q[g] <= src;
            end
        end

        assign taps_o[g*W +: W] = stage_q[g];
    end
endmodule

// File: rtl/cvt_sample_sequencer.sv
module cvt_sample_sequencer #(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned FS_HZ      = 44_100,
    parameter int unsigned SCLK_DIV   = 2,
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned SAMPLE_W   = 12,
    parameter int unsigned TAPS       = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SAMPLE_W-1:0]      adc_word_i,
    input  logic [SAMPLE_W-1:0]      dac_word_i,
    output logic                     sample_tick_o,
    output logic                     adc_rd_en_o,
    output logic                     adc_cs_n_o,
    output logic                     sample_done_o,
    output logic                     dac_wr_en_o,
    output logic                     dac_sync_n_o,
    output logic [SAMPLE_W-1:0]      dac_word_o,
    output logic [TAPS*SAMPLE_W-1:0] taps_o
);
    localparam int unsigned PERIOD     = smp_pkg::ticks_per_sample(CLK_HZ, FS_HZ);
    localparam int unsigned FRAME_CLKS = FRAME_BITS * SCLK_DIV;

    smp_pkg::seq_ctl_t ctl;
    logic              tick;
    logic [SAMPLE_W-1:0] dac_word_q;

    smp_rate_div #(.PERIOD(PERIOD)) u_div (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    smp_frame_fsm #(.FRAME_CLKS(FRAME_CLKS)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .ctl_o  (ctl)
    );

    smp_delay_line #(.W(SAMPLE_W), .TAPS(TAPS)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .shift_i (ctl.done),
        .din_i   (adc_word_i),
        .taps_o  (taps_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_word_q <= '0;
        end else if (ctl.done) begin
            dac_word_q <= dac_word_i;
        end
    end

    assign sample_tick_o = tick;
    assign adc_rd_en_o   = ctl.rd_en;
    assign adc_cs_n_o    = ~ctl.rd_en;
    assign sample_done_o = ctl.done;
    assign dac_wr_en_o   = ctl.wr_en;
    assign dac_sync_n_o  = ~ctl.wr_en;
    assign dac_word_o    = dac_word_q;
endmodule

// File: rtl/smp_seq_checker.sv
module smp_seq_checker #(
    parameter int unsigned W          = 12,
    parameter int unsigned TAPS       = 8,
    parameter int unsigned FRAME_CLKS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              rd_en,
    input logic              wr_en,
    input logic              done,
    input logic [W-1:0]      adc_word,
    input logic [TAPS*W-1:0] taps
);
    localparam int unsigned RW = $clog2(FRAME_CLKS + 1) + 1;
    localparam logic [RW-1:0] FRAME_N = RW'(FRAME_CLKS);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (rd_en) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

    p_done_in_acq_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> rd_en);

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_dac_follows_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> (wr_en && !rd_en));

    p_idle_start_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !rd_en && !wr_en) |=> rd_en);

    p_acq_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_en) |-> (run_q == FRAME_N));

    p_resume_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(wr_en) && $past(tick)) |-> rd_en);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(taps));

    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (taps[W-1:0] == $past(adc_word)));
endmodule

bind cvt_sample_sequencer smp_seq_checker #(
    .W          (SAMPLE_W),
    .TAPS       (TAPS),
    .FRAME_CLKS (FRAME_BITS * SCLK_DIV)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (sample_tick_o),
    .rd_en    (adc_rd_en_o),
    .wr_en    (dac_wr_en_o),
    .done     (sample_done_o),
    .adc_word (adc_word_i),
    .taps     (taps_o)
);

// File: tb/sim_cvt_sample_sequencer.sv
module sim_cvt_sample_sequencer;
    localparam int W = 8;
    localparam int T = 3;
    localparam int F = 8;      // 4 frame bits x 2 clocks
    localparam int NCYC = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] adc_w = '0;
    logic [W-1:0] dac_w = '0;

    logic a_tick, a_rd, a_cs_n, a_done, a_wr, a_sync_n;
    logic [W-1:0] a_dw;
    logic [T*W-1:0] a_taps;
    logic b_tick, b_rd, b_cs_n, b_done, b_wr, b_sync_n;
    logic [W-1:0] b_dw;
    logic [T*W-1:0] b_taps;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // 196/10 rounds to a 20-clock period: idle gaps between frames.
    cvt_sample_sequencer #(.CLK_HZ(196), .FS_HZ(10), .SCLK_DIV(2), .FRAME_BITS(4),
                           .SAMPLE_W(W), .TAPS(T)) u0 (
        .clk(clk), .rst(rst), .adc_word_i(adc_w), .dac_word_i(dac_w),
        .sample_tick_o(a_tick), .adc_rd_en_o(a_rd), .adc_cs_n_o(a_cs_n),
        .sample_done_o(a_done), .dac_wr_en_o(a_wr), .dac_sync_n_o(a_sync_n),
        .dac_word_o(a_dw), .taps_o(a_taps));

    // 118/10 rounds to a 12-clock period: ticks land inside frames.
    cvt_sample_sequencer #(.CLK_HZ(118), .FS_HZ(10), .SCLK_DIV(2), .FRAME_BITS(4),
                           .SAMPLE_W(W), .TAPS(T)) u1 (
        .clk(clk), .rst(rst), .adc_word_i(adc_w), .dac_word_i(dac_w),
        .sample_tick_o(b_tick), .adc_rd_en_o(b_rd), .adc_cs_n_o(b_cs_n),
        .sample_done_o(b_done), .dac_wr_en_o(b_wr), .dac_sync_n_o(b_sync_n),
        .dac_word_o(b_dw), .taps_o(b_taps));

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int period_of(int inst);
        return (inst == 0) ? 20 : 12;
    endfunction

    // 0 idle, 1 acquisition, 2 output frame; position 0..F-1 within the window.
    function automatic int phase_of(int inst, int c);
        int p;
        if (inst == 0) begin
            if (c < 20) return 0;
            p = c % 20;
            return (p < F) ? 1 : ((p < 2*F) ? 2 : 0);
        end
        if (c < 12) return 0;
        p = (c - 12) % (2*F);
        return (p < F) ? 1 : 2;
    endfunction

    function automatic bit done_of(int inst, int c);
        if (inst == 0) return (c >= 20) && (c % 20 == F - 1);
        return (c >= 12) && ((c - 12) % (2*F) == F - 1);
    endfunction

    function automatic logic [W-1:0] adc_val(int c);
        return W'(c * 37 + 11);
    endfunction

    function automatic logic [W-1:0] dac_val(int c);
        return W'(c * 53 + 7);
    endfunction

    logic [T*W-1:0] exp_ta = '0, exp_tb = '0;
    logic [W-1:0]   exp_da = '0, exp_db = '0;

    task automatic check_inst(int inst, int c, logic tick, logic rd, logic cs_n, logic done,
                              logic wr, logic sync_n, logic [W-1:0] dw,
                              logic [T*W-1:0] taps, logic [T*W-1:0] et, logic [W-1:0] ed);
        int ph;
        string rq_seq;
        ph = phase_of(inst, c);
        rq_seq = (inst == 1) ? "R6" : "R3";
        chk("R1", $sformatf("u%0d tick c=%0d", inst, c), int'(tick),
            int'(c % period_of(inst) == period_of(inst) - 1));
        chk(rq_seq, $sformatf("u%0d rd_en c=%0d", inst, c), int'(rd), int'(ph == 1));
        chk(rq_seq, $sformatf("u%0d cs_n c=%0d", inst, c), int'(cs_n), int'(ph != 1));
        chk("R4", $sformatf("u%0d done c=%0d", inst, c), int'(done), int'(done_of(inst, c)));
        chk("R5", $sformatf("u%0d wr_en c=%0d", inst, c), int'(wr), int'(ph == 2));
        chk("R5", $sformatf("u%0d sync_n c=%0d", inst, c), int'(sync_n), int'(ph != 2));
        chk("R9", $sformatf("u%0d exclusive c=%0d", inst, c), int'(rd && wr), 0);
        chk("R8", $sformatf("u%0d dac_word c=%0d", inst, c), int'(dw), int'(ed));
        for (int k = 0; k < T; k++) begin
            chk("R7", $sformatf("u%0d tap%0d c=%0d", inst, k, c),
                int'(taps[k*W +: W]), int'(et[k*W +: W]));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: state held by reset.
        chk("R2", "u0 rd_en", int'(a_rd), 0);
        chk("R2", "u0 cs_n", int'(a_cs_n), 1);
        chk("R2", "u0 sync_n", int'(a_sync_n), 1);
        chk("R2", "u0 taps", int'(a_taps), 0);
        chk("R2", "u0 dac_word", int'(a_dw), 0);
        chk("R2", "u1 wr_en", int'(b_wr), 0);
        chk("R2", "u1 done", int'(b_done), 0);
        chk("R2", "u1 taps", int'(b_taps), 0);
        rst = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            if (c > 0) @(negedge clk);
            check_inst(0, c, a_tick, a_rd, a_cs_n, a_done, a_wr, a_sync_n, a_dw, a_taps,
                       exp_ta, exp_da);
            check_inst(1, c, b_tick, b_rd, b_cs_n, b_done, b_wr, b_sync_n, b_dw, b_taps,
                       exp_tb, exp_db);
            adc_w = adc_val(c);
            dac_w = dac_val(c);
            if (done_of(0, c)) begin
                exp_ta = {exp_ta[(T-1)*W-1:0], adc_w};
                exp_da = dac_w;
            end
            if (done_of(1, c)) begin
                exp_tb = {exp_tb[(T-1)*W-1:0], adc_w};
                exp_db = dac_w;
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule